// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Correction

This block sits behind an eight-stage pipelined analog-to-digital converter and turns the raw decisions of its stages into one 10-bit output word per clock. Seven front stages each resolve a redundant decision that can take three values. An eighth stage is a small flash converter with a 7-bit thermometer output. Each stage works on a given analog sample one clock after the stage before it. The block therefore delays every stage by a different amount, so that all eight decisions for one sample meet in the same cycle.

After alignment, the flash thermometer is cleaned of bubbles by a neighbour majority vote. The cleaned code becomes a one-hot position and then a 3-bit value. The seven redundant decisions are added with overlapping binary weights, and the flash value is added as the least significant part. The overlap absorbs comparator offsets in the front stages: two different decision sets that describe the same input give the same word. A valid flag travels through the block with the same latency as the data.

Top module: `pipe_adc_corr`

## Requirements
- R1: While reset is held and in the cycle after it is released, `out_valid` is 0 and `out_code` is 0.
- R2: Front stage i (1..7) reports its decision on `stage_codes[2i-1:2i-2]` as 0, 1 or 2. The value 3 is illegal and is weighted exactly as 2.
- R3: The decision of front stage i for a sample arrives i−1 cycles after that sample's stage-1 decision. The flash thermometer arrives 7 cycles after it. The block pairs exactly these inputs together.
- R4: `out_code` = Σ d_i·2^(9−i) over i = 1..7, plus the flash value f, limited to 0..1023. All decisions at 1 with f = 4 gives 512. All decisions at 0 with f = 0 gives 0. All decisions at 2 with f = 7 gives 1023.
- R5: `flash_therm[k]` is comparator k (k = 0..6). A bubble-free thermometer with m bits set from bit 0 upward gives f = m.
- R6: Bubble removal first replaces each thermometer bit by the majority of itself and its two neighbours. Below bit 0 the neighbour counts as 1, and above bit 6 it counts as 0. f is then the position just above the highest set bit of the cleaned code, or 0 if no bit is set.
- R7: `out_code` and `out_valid` for a sample are updated at the clock edge 7 cycles after the edge that captures its stage-1 decision and `in_valid`.
- R8: Decision sets that differ only by a carry between adjacent stages produce the same word. For example, (d1=1, d2=2) equals (d1=2, d2=0) when all other inputs are the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Marks a new sample alongside its stage-1 decision |
| stage_codes | input | 14 | Seven 2-bit front-stage decisions, stage 1 in the low bits |
| flash_therm | input | 7 | Flash comparator outputs, bit k is comparator k |
| out_valid | output | 1 | Output word is valid |
| out_code | output | 10 | Corrected converter word |

## Verification
The assertions check several things on every cycle. The word at mid scale, at both ends of the range and with all-illegal decisions must be correct. A bubble-free thermometer must decode to its count of ones. The cleaned thermometer must give exactly one hot position whenever it is monotonic. Valid must stay low until the pipeline has filled since reset. Only the bench's scenarios can show correct pairing of skewed inputs from eight different cycles, the handling of isolated bubbles and spikes, and carry equivalence between redundant decision sets. The bench shows these by driving each sample with its true stage skew and comparing every cycle against a model built per sample.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  parameter int NSTG   = 7;                 // redundant front stages
  parameter int FB     = 3;                 // flash resolution in bits
  parameter int OW     = 10;                // output word width
  localparam int TW    = (1 << FB) - 1;     // thermometer width
  localparam int LAT   = NSTG + 1;          // edges from stage-1 capture to output
  localparam int MAXC  = (1 << OW) - 1;

  // Illegal decision 3 folds onto 2.
  function automatic logic [1:0] fold_code(input logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : c;
  endfunction

  // Overlapping-weight sum: stage g (0-based) carries 2^(OW-2-g).
  function automatic logic [OW-1:0] merge_word(input logic [2*NSTG-1:0] codes,
                                               input logic [FB-1:0] fval);
    int acc;
    acc = int'(fval);
    for (int g = 0; g < NSTG; g++)
      acc += int'(fold_code(codes[2*g +: 2])) << (OW - 2 - g);
    if (acc > MAXC) acc = MAXC;
    if (acc < 0) acc = 0;
    return acc[OW-1:0];
  endfunction
endpackage

// File: rtl/skew_delay.sv
module skew_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_regs
      logic [W-1:0] tap_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) tap_q[k] <= '0;
        end else begin
          tap_q[0] <= din;
          for (int k = 1; k < DEPTH; k++) tap_q[k] <= tap_q[k-1];
        end
      end
      assign dout = tap_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/flash_decode.sv
module flash_decode
  import adc_corr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] therm,
  output logic [FB-1:0] fval
);
  logic [TW+1:0] therm_ext;   // bit 0 = virtual 1 below, top = virtual 0 above
  logic [TW-1:0] clean_th;    // majority-filtered thermometer
  logic [TW+1:0] clean_ext;
  logic [TW:0]   hot_pos;     // one-hot position 0..TW

  assign therm_ext = {1'b0, therm, 1'b1};
  assign clean_ext = {1'b0, clean_th, 1'b1};

  always_comb begin
    for (int k = 0; k < TW; k++)
      clean_th[k] = (therm_ext[k] & therm_ext[k+1]) | (therm_ext[k] & therm_ext[k+2]) |
                    (therm_ext[k+1] & therm_ext[k+2]);
    for (int v = 0; v <= TW; v++)
      hot_pos[v] = clean_ext[v] & ~clean_ext[v+1];
  end

  always_comb begin
    fval = '0;
    for (int v = 0; v <= TW; v++)
      if (hot_pos[v]) fval = FB'(v);
  end

  assert_flash_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, therm} & ({1'b0, therm} + 1'b1)) == '0) |-> (int'(fval) == $countones(therm)));

  assert_onehot_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, clean_th} & ({1'b0, clean_th} + 1'b1)) == '0) |-> $onehot(hot_pos));
endmodule

// File: rtl/pipe_adc_corr.sv
module pipe_adc_corr
  import adc_corr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*NSTG-1:0]   stage_codes,
  input  logic [TW-1:0]       flash_therm,
  output logic                out_valid,
  output logic [OW-1:0]       out_code
);
  localparam int CW = $clog2(LAT + 1);

  logic [2*NSTG-1:0] aligned_codes;
  logic              valid_aligned;
  logic [FB-1:0]     flash_val;

  generate
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
      skew_delay #(.W(2), .DEPTH(NSTG - g)) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (stage_codes[2*g +: 2]),
        .dout (aligned_codes[2*g +: 2])
      );
    end
  endgenerate

  skew_delay #(.W(1), .DEPTH(NSTG)) u_vdly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (in_valid),
    .dout (valid_aligned)
  );

  flash_decode u_fd (
    .clk  (clk),
    .rst_n(rst_n),
    .therm(flash_therm),
    .fval (flash_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_code  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_code  <= merge_word(aligned_codes, flash_val);
      out_valid <= valid_aligned;
    end
  end

  // Fill counter for the latency check.
  logic [CW-1:0] fill_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_cnt <= '0;
    else if (int'(fill_cnt) < LAT) fill_cnt <= fill_cnt + 1'b1;
  end

  assert_valid_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_cnt) < LAT) |-> !out_valid);

  assert_mid_scale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((aligned_codes == {NSTG{2'd1}}) && (int'(flash_val) == (1 << (FB-1))))
      |=> (int'(out_code) == (1 << (OW-1))));

  assert_full_scale_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((aligned_codes == {NSTG{2'd2}}) && (int'(flash_val) == TW)) |=> (int'(out_code) == MAXC));

  assert_illegal_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((aligned_codes == {NSTG{2'd3}}) && (int'(flash_val) == TW)) |=> (int'(out_code) == MAXC));
endmodule

// File: tb/pipe_adc_corr_tb_top.sv
module pipe_adc_corr_tb_top;
  localparam int NS = 7;
  localparam int N  = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] stage_codes = '0;
  logic [6:0]  flash_therm = '0;
  logic        out_valid;
  logic [9:0]  out_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int    sd [N][1:NS];
  int    st [N];
  bit    sv [N];
  string tag [N];

  always #2.5 clk = ~clk;

  pipe_adc_corr dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .stage_codes(stage_codes), .flash_therm(flash_therm),
    .out_valid(out_valid), .out_code(out_code)
  );

  function automatic int flash_ref(input int t);
    int c, top, lo, hi;
    c = 0;
    for (int k = 0; k < 7; k++) begin
      lo = (k == 0) ? 1 : (t >> (k-1)) & 1;
      hi = (k == 6) ? 0 : (t >> (k+1)) & 1;
      if (lo + ((t >> k) & 1) + hi >= 2) c |= (1 << k);
    end
    top = 0;
    for (int k = 0; k < 7; k++) if ((c >> k) & 1) top = k + 1;
    return top;
  endfunction

  function automatic int word_ref(input int n);
    int acc, d;
    if (n < 0) return 0;
    acc = 512 + flash_ref(st[n]) - 4;
    for (int i = 1; i <= NS; i++) begin
      d = (sd[n][i] == 3) ? 2 : sd[n][i];
      acc += (d - 1) * (256 >> (i - 1));
    end
    if (acc > 1023) acc = 1023;
    if (acc < 0) acc = 0;
    return acc;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_sample(input int n, input int dall, input int t, input string tg);
    for (int i = 1; i <= NS; i++) sd[n][i] = dall;
    st[n] = t; sv[n] = 1'b1; tag[n] = tg;
  endtask

  task automatic drive(input int n);
    logic [13:0] sc;
    sc = '0;
    for (int i = 1; i <= NS; i++) begin
      int src;
      src = n - i + 1;
      if (src >= 0 && src < N) sc[2*(i-1) +: 2] = 2'(sd[src][i]);
    end
    stage_codes = sc;
    flash_therm = (n - 7 >= 0 && n - 7 < N) ? 7'(st[n-7]) : 7'd0;
    in_valid    = (n < N) ? sv[n] : 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < N; n++) begin
      for (int i = 1; i <= NS; i++) sd[n][i] = $urandom_range(0, 3);
      st[n]  = $urandom_range(0, 127);
      sv[n]  = 1'($urandom_range(0, 1));
      tag[n] = "R3";
    end
    for (int n = 0; n < 10; n++) begin
      for (int i = 1; i <= NS; i++) sd[n][i] = 0;
      st[n] = 0; sv[n] = 0;
    end
    set_sample(10, 1, 7'b0001111, "R4");
    set_sample(11, 0, 7'b0000000, "R4");
    set_sample(12, 2, 7'b1111111, "R4");
    set_sample(13, 3, 7'b1111111, "R2");
    set_sample(14, 1, 7'b0001111, "R2"); sd[14][3] = 3;
    set_sample(15, 1, 7'b0001111, "R8"); sd[15][2] = 2;
    set_sample(16, 1, 7'b0001111, "R8"); sd[16][1] = 2; sd[16][2] = 0;
    set_sample(17, 1, 7'b0001011, "R6");
    set_sample(18, 1, 7'b0100011, "R6");
    for (int m = 0; m <= 7; m++) set_sample(19 + m, 1, (1 << m) - 1, "R5");

    #12 check("R1", int'(out_valid), 0);
    check("R1", int'(out_code), 0);
    @(negedge clk);
    drive(0);
    rst_n = 1'b1;
    for (int n = 0; n < N + 8; n++) begin
      @(posedge clk);
      #2;
      if (n == 0) begin
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_code), 0);
      end
      check("R7", int'(out_valid), (n - 7 >= 0 && n - 7 < N) ? int'(sv[n-7]) : 0);
      if (n - 7 >= 0 && n - 7 < N) check(tag[n-7], int'(out_code), word_ref(n - 7));
      else if (n - 7 < 0) check("R1", int'(out_code), 0);
      drive(n + 1);
    end
    check("R4", word_ref(10), 512);
    check("R8", word_ref(15), word_ref(16));
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule